// File: doc/BRIEF.md
# Register-Mapped External RAM Window

This block gives a small processor core access to a 64 KB external data RAM through its ordinary register-select path. Three 8-bit pointer registers (a page byte, an offset byte and an index byte) set the external address. Their effective address is the page times 256, plus the offset, plus the index, with the result kept to 16 bits. A fourth select code is a data window. Reading it reads the RAM location at the effective address, and writing it writes that location. The core therefore reaches external memory with the same read and write it uses for any register.

All address and strobe outputs are combinational from the registered pointers and the request of the current cycle. A window access completes in the cycle it is requested, with a one-cycle strobe. A pointer write is taken at the next rising clock edge and moves the address from then on.

Top module: `xram_window`

## Requirements
- R1: During and after reset, the page, offset and index registers are all zero, so `mem_addr` is 0x0000.
- R2: A write (`cpu_wr`=1) with `cpu_sel` 0, 1 or 2 loads `cpu_wdata` into the page, offset or index register respectively at the next rising edge. A read with the same code returns that register's value on `cpu_rdata` in the same cycle.
- R3: `mem_addr` always equals (page*256 + offset + index) mod 65536. The index carries into the page byte, and the sum wraps past 0xFFFF.
- R4: A read with `cpu_sel`=3 and `cpu_wr`=0 raises `mem_rd` for that cycle, and `cpu_rdata` equals `mem_rdata` in the same cycle.
- R5: A write with `cpu_sel`=3 raises `mem_wr` for that cycle with `mem_wdata` equal to `cpu_wdata`, and leaves all three pointer registers unchanged.
- R6: If `cpu_rd` and `cpu_wr` are both high, the write is performed and the read is suppressed: `mem_rd` stays low and `cpu_rdata` is 0.
- R7: Select codes 4 to 7 are unmapped. Writes to them change no pointer register, reads return 0, and no memory strobe is raised.
- R8: With no request, `mem_rd` and `mem_wr` are low, `cpu_rdata` is 0 and `mem_wdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 3 | Register select code |
| cpu_rd | input | 1 | Read request for the selected register |
| cpu_wr | input | 1 | Write request for the selected register |
| cpu_wdata | input | 8 | Write data from the core |
| cpu_rdata | output | 8 | Read data to the core |
| mem_addr | output | 16 | External RAM address |
| mem_wdata | output | 8 | External RAM write data |
| mem_rdata | input | 8 | External RAM read data |
| mem_rd | output | 1 | External RAM read strobe |
| mem_wr | output | 1 | External RAM write strobe |

## Verification
Directed cases place the address at its arithmetic edges. An index carry that ripples into the page byte separates a true 16-bit add from a concatenation. An all-ones pointer plus index shows that the sum wraps instead of saturating. A zero index shows that the offset is not altered. Random sequences mix pointer loads, window reads and writes, simultaneous read-and-write requests and unmapped codes. This mix separates correct select decoding and write priority from near misses, and shows that window traffic never disturbs the pointers. Random RAM read data exposes any wrong source selected for the core's read bus.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int DW  = 8;
    localparam int AW  = 2 * DW;
    localparam int SW  = 3;

    localparam logic [SW-1:0] SEL_PAGE  = 3'd0;
    localparam logic [SW-1:0] SEL_OFFS  = 3'd1;
    localparam logic [SW-1:0] SEL_INDEX = 3'd2;
    localparam logic [SW-1:0] SEL_WIN   = 3'd3;

    typedef struct packed {
        logic [DW-1:0] page;
        logic [DW-1:0] offs;
        logic [DW-1:0] idx;
    } ptr_s;
endpackage

// File: rtl/xw_ptr_regs.sv
module xw_ptr_regs
    import xw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] sel,
    input  logic [DW-1:0] wdata,
    output ptr_s          ptr
);
    ptr_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) begin
            case (sel)
                SEL_PAGE:  s_d.page = wdata;
                SEL_OFFS:  s_d.offs = wdata;
                SEL_INDEX: s_d.idx  = wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ptr = s_q;

    a_r2_page_load: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_PAGE) |=> (s_q.page == $past(wdata)));
    a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_INDEX) |=> (s_q.idx == $past(wdata)));
    a_r5_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == SEL_PAGE) |=> $stable(s_q.page));
    a_r5_offs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == SEL_OFFS) |=> $stable(s_q.offs));
    a_r7_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == SEL_INDEX) |=> $stable(s_q.idx));
endmodule

// File: rtl/xw_addr_sum.sv
module xw_addr_sum
    import xw_pkg::*;
(
    input  ptr_s          ptr,
    output logic [AW-1:0] addr
);
    localparam int PAD = AW - DW;
    logic [AW-1:0] base;
    logic [AW-1:0] ext_idx;

    assign base    = {ptr.page, ptr.offs};
    assign ext_idx = {{PAD{1'b0}}, ptr.idx};
    assign addr    = base + ext_idx;
endmodule

// File: rtl/xw_access_dec.sv
module xw_access_dec
    import xw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sel,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  ptr_s          ptr,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] cpu_rdata
);
    logic rd_eff;
    assign rd_eff = rd && !wr;

    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        cpu_rdata = '0;
        if (wr && sel == SEL_WIN) begin
            mem_wr    = 1'b1;
            mem_wdata = wdata;
        end
        if (rd_eff) begin
            case (sel)
                SEL_PAGE:  cpu_rdata = ptr.page;
                SEL_OFFS:  cpu_rdata = ptr.offs;
                SEL_INDEX: cpu_rdata = ptr.idx;
                SEL_WIN: begin
                    mem_rd    = 1'b1;
                    cpu_rdata = mem_rdata;
                end
                default:   cpu_rdata = '0;
            endcase
        end
    end

    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_rd, mem_wr}) <= 1);
    a_r4_rd_data: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (cpu_rdata == mem_rdata));
    a_r5_wr_data: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == wdata));
    a_r8_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (cpu_rdata == '0));
endmodule

// File: rtl/xram_window.sv
module xram_window
    import xw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] cpu_sel,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_rd,
    output logic          mem_wr
);
    ptr_s ptr;

    xw_ptr_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cpu_wr),
        .sel   (cpu_sel),
        .wdata (cpu_wdata),
        .ptr   (ptr)
    );

    xw_addr_sum u_sum (
        .ptr  (ptr),
        .addr (mem_addr)
    );

    xw_access_dec u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (cpu_sel),
        .rd        (cpu_rd),
        .wr        (cpu_wr),
        .wdata     (cpu_wdata),
        .ptr       (ptr),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .cpu_rdata (cpu_rdata)
    );

    a_r5_addr_hold_on_win_wr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> $stable(mem_addr));
    a_r7_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel[2]) |-> (!mem_rd && !mem_wr));
endmodule

// File: tb/xram_window_tb_top.sv
module xram_window_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cpu_sel = '0;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = '0;
    logic       mem_rd;
    logic       mem_wr;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_page = '0, m_offs = '0, m_idx = '0;

    always #2.5 clk = ~clk;

    xram_window dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    function automatic logic [15:0] exp_addr(logic [7:0] p, logic [7:0] o, logic [7:0] i);
        logic [16:0] s;
        s = 17'(p) * 17'd256 + 17'(o) + 17'(i);
        return s[15:0];
    endfunction

    function automatic logic [7:0] exp_rdata(logic [2:0] s, logic r, logic w, logic [7:0] md);
        if (!r || w) return 8'h00;
        case (s)
            3'd0: return m_page;
            3'd1: return m_offs;
            3'd2: return m_idx;
            3'd3: return md;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(logic [2:0] s, logic r, logic w, logic [7:0] d, logic [7:0] md);
        @(negedge clk);
        cpu_sel = s; cpu_rd = r; cpu_wr = w; cpu_wdata = d; mem_rdata = md;
        #1;
        chk("R3 address", mem_addr, exp_addr(m_page, m_offs, m_idx));
        chk("R4/R6/R7 read strobe", 16'(mem_rd), 16'(r && !w && s == 3'd3));
        chk("R5/R7 write strobe", 16'(mem_wr), 16'(w && s == 3'd3));
        chk("R5/R8 write data", 16'(mem_wdata), (w && s == 3'd3) ? 16'(d) : 16'h0);
        chk("R2/R4/R7/R8 read data", 16'(cpu_rdata), 16'(exp_rdata(s, r, w, md)));
        @(posedge clk);
        if (w) begin
            case (s)
                3'd0: m_page = d;
                3'd1: m_offs = d;
                3'd2: m_idx  = d;
                default: ;
            endcase
        end
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        #1;
        chk("R1 address in reset", mem_addr, 16'h0000);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 address after reset", mem_addr, 16'h0000);
        op(3'd0, 1'b0, 1'b0, 8'h00, 8'h00);             // R8 idle
        // R3 carry into page byte
        op(3'd0, 1'b0, 1'b1, 8'h12, 8'h00);
        op(3'd1, 1'b0, 1'b1, 8'hFF, 8'h00);
        op(3'd2, 1'b0, 1'b1, 8'h01, 8'h00);
        op(3'd0, 1'b0, 1'b0, 8'h00, 8'h00);
        chk("R3 carry 0x1300", mem_addr, 16'h1300);
        // R3 wrap at 0xFFFF
        op(3'd0, 1'b0, 1'b1, 8'hFF, 8'h00);
        op(3'd2, 1'b0, 1'b1, 8'h02, 8'h00);
        op(3'd0, 1'b1, 1'b0, 8'h00, 8'h00);             // R2 readback
        chk("R3 wrap 0x0001", mem_addr, 16'h0001);
        // R4 window read, R5 window write, R6 both
        op(3'd3, 1'b1, 1'b0, 8'h00, 8'hA5);
        op(3'd3, 1'b0, 1'b1, 8'h3C, 8'h00);
        op(3'd3, 1'b1, 1'b1, 8'hC3, 8'h77);
        chk("R5 pointers unchanged", mem_addr, 16'h0001);
        // R7 unmapped codes
        for (int c = 4; c < 8; c++) op(3'(c), 1'b1, 1'b1, 8'h55, 8'h99);
        for (int c = 4; c < 8; c++) op(3'(c), 1'b1, 1'b0, 8'h00, 8'h99);
        chk("R7 unmapped writes ignored", mem_addr, 16'h0001);
        // random mix
        for (int n = 0; n < 400; n++) begin
            op(3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom_range(0, 3) == 0),
               8'($urandom), 8'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule